// File: doc/BRIEF.md
# MSI Doorbell Write Decoder

This block is a memory-mapped window that devices write to when they signal a message interrupt. Each write offset selects a table slot, and each slot is a 64 KiB region of the window. The offset and the write data together give a vector number. The block adds that vector number to the slot's base interrupt number and sends the result to the interrupt controller as a one-cycle pulse. The same decode serves both interrupt styles. The per-vector style places the vector in offset bits 15:2 and writes data zero. The single-message style writes to the slot base and carries the vector in the low data bits. The decoder ORs the two sources, so it does not need to know which style the device uses.

The allocation logic, which lies outside this block, fills a small register file through a load port. Each entry holds a base interrupt number and a vector count. A count of zero marks the slot as unused. Writes to a slot that is unused, or that lies above the table, are dropped and raise an error pulse instead. Reads of the window have no defined content: they are acknowledged one cycle later with zero data and have no other effect.

Top module: `msi_doorbell`

## Requirements
- R1: After reset, irq_valid, irq_err and rd_ack are low and every slot is unused, so a write to any slot produces an error pulse.
- R2: The slot index of a write is its window offset shifted right by 16 bits, which is acc_addr[ADDR_W-1:16].
- R3: The vector is acc_addr[15:2] ORed with acc_wdata. acc_wdata is little-endian, so byte lane 0 is acc_wdata[7:0]. irq_num is the slot base plus this vector, modulo 2^IRQ_W.
- R4: An accepted write to a used slot raises irq_valid for exactly the one cycle after the write edge. Writes in back-to-back cycles give pulses in back-to-back cycles, each with its own number.
- R5: A write whose index is NUM_ENT or above raises irq_err for one cycle and raises no irq_valid.
- R6: A write to a slot whose vector count is zero raises irq_err for one cycle and raises no irq_valid.
- R7: A read raises rd_ack in the following cycle with rd_data zero. It raises neither irq_valid nor irq_err, and it changes no slot.
- R8: A load and a write to the same slot in the same cycle: the write uses the slot's previous contents, and the load takes effect from the next cycle.
- R9: Loading a slot with a count of zero returns it to unused, so later writes to it raise irq_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Window access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Offset within the window |
| acc_wdata | input | 32 | Write data, little-endian |
| rd_ack | output | 1 | Read completed |
| rd_data | output | 32 | Read data, always zero |
| cfg_load | input | 1 | Load a slot |
| cfg_idx | input | SLOT_W | Slot to load |
| cfg_base | input | IRQ_W | Base interrupt number |
| cfg_count | input | CNT_W | Vector count, 0 = unused |
| irq_valid | output | 1 | Interrupt pulse |
| irq_num | output | IRQ_W | Global interrupt number |
| irq_err | output | 1 | Dropped write pulse |

## Verification
A slot load and a doorbell write that targets that same slot can arrive on the same clock edge. The bench produces this case by driving cfg_load and a window write together. It then checks that the pulse carries the number formed from the old base, or an error when the slot was empty before. A second write, sent in the next cycle, must show the newly loaded base.

// File: rtl/msi_pkg.sv
package msi_pkg;
  function automatic logic [31:0] vec_of(input logic [15:0] off, input logic [31:0] data);
    return {18'd0, off[15:2]} | data;
  endfunction
endpackage

// File: rtl/msi_win_decode.sv
module msi_win_decode #(
  parameter int WIN_IDX_W = 4,
  parameter int NUM_ENT   = 8,
  parameter int IRQ_W     = 16,
  localparam int ADDR_W   = WIN_IDX_W + 16
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wdata,
  output logic [WIN_IDX_W-1:0] idx,
  output logic [IRQ_W-1:0]     vec,
  output logic                 in_range
);
  // R2: 64 KiB per slot
  assign idx      = addr[ADDR_W-1:16];
  assign in_range = 32'(idx) < NUM_ENT;
  // R3: both interrupt styles merge here
  assign vec      = IRQ_W'(msi_pkg::vec_of(addr[15:0], wdata));
endmodule

// File: rtl/msi_base_file.sv
module msi_base_file #(
  parameter int NUM_ENT   = 8,
  parameter int IRQ_W     = 16,
  parameter int CNT_W     = 6,
  parameter int WIN_IDX_W = 4,
  localparam int SLOT_W   = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_en,
  input  logic [SLOT_W-1:0]    ld_idx,
  input  logic [IRQ_W-1:0]     ld_base,
  input  logic [CNT_W-1:0]     ld_count,
  input  logic [WIN_IDX_W-1:0] rd_idx,
  output logic [IRQ_W-1:0]     rd_base,
  output logic                 rd_used
);
  logic [IRQ_W-1:0] base_q [NUM_ENT];
  logic [CNT_W-1:0] cnt_q  [NUM_ENT];

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    logic hit;
    assign hit = ld_en && (32'(ld_idx) == i);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[i] <= '0;
        cnt_q[i]  <= '0;
      end else if (hit) begin
        base_q[i] <= ld_base;
        cnt_q[i]  <= ld_count;
      end
    end
    // R9: a load lands in the addressed slot on the next cycle
    a_r9_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (cnt_q[i] == $past(ld_count)) && (base_q[i] == $past(ld_base)));
  end

  // Read port sees pre-load contents (R8)
  always_comb begin
    rd_base = '0;
    rd_used = 1'b0;
    for (int k = 0; k < NUM_ENT; k++) begin
      if (32'(rd_idx) == k) begin
        rd_base = base_q[k];
        rd_used = cnt_q[k] != '0;
      end
    end
  end
endmodule

// File: rtl/msi_pulse_stage.sv
module msi_pulse_stage #(
  parameter int IRQ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_ok,
  input  logic             fire_bad,
  input  logic             rd_fire,
  input  logic [IRQ_W-1:0] num_d,
  output logic             irq_valid,
  output logic [IRQ_W-1:0] irq_num,
  output logic             irq_err,
  output logic             rd_ack
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_valid <= 1'b0;
      irq_err   <= 1'b0;
      rd_ack    <= 1'b0;
      irq_num   <= '0;
    end else begin
      irq_valid <= fire_ok;
      irq_err   <= fire_bad;
      rd_ack    <= rd_fire;
      if (fire_ok) irq_num <= num_d;
    end
  end

  // R4 / R5 / R6: a pulse is either good or an error, never both
  a_r4_pulse_or_err: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_valid && irq_err));
endmodule

// File: rtl/msi_doorbell.sv
module msi_doorbell #(
  parameter int NUM_ENT   = 8,
  parameter int WIN_IDX_W = 4,
  parameter int IRQ_W     = 16,
  parameter int CNT_W     = 6,
  localparam int ADDR_W   = WIN_IDX_W + 16,
  localparam int SLOT_W   = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [31:0]       acc_wdata,
  output logic              rd_ack,
  output logic [31:0]       rd_data,
  input  logic              cfg_load,
  input  logic [SLOT_W-1:0] cfg_idx,
  input  logic [IRQ_W-1:0]  cfg_base,
  input  logic [CNT_W-1:0]  cfg_count,
  output logic              irq_valid,
  output logic [IRQ_W-1:0]  irq_num,
  output logic              irq_err
);
  logic [WIN_IDX_W-1:0] dec_idx;
  logic [IRQ_W-1:0]     dec_vec;
  logic                 dec_in_range;
  logic [IRQ_W-1:0]     slot_base;
  logic                 slot_used;
  logic                 wr_fire, rd_fire, fire_ok, fire_bad;

  msi_win_decode #(.WIN_IDX_W(WIN_IDX_W), .NUM_ENT(NUM_ENT), .IRQ_W(IRQ_W)) dec_u (
    .addr(acc_addr), .wdata(acc_wdata), .idx(dec_idx), .vec(dec_vec), .in_range(dec_in_range));

  msi_base_file #(.NUM_ENT(NUM_ENT), .IRQ_W(IRQ_W), .CNT_W(CNT_W), .WIN_IDX_W(WIN_IDX_W)) file_u (
    .clk(clk), .rst_n(rst_n), .ld_en(cfg_load), .ld_idx(cfg_idx), .ld_base(cfg_base),
    .ld_count(cfg_count), .rd_idx(dec_idx), .rd_base(slot_base), .rd_used(slot_used));

  assign wr_fire  = acc_valid && acc_write;
  assign rd_fire  = acc_valid && !acc_write;
  assign fire_ok  = wr_fire && dec_in_range && slot_used;
  assign fire_bad = wr_fire && !(dec_in_range && slot_used);
  assign rd_data  = '0;

  msi_pulse_stage #(.IRQ_W(IRQ_W)) out_u (
    .clk(clk), .rst_n(rst_n), .fire_ok(fire_ok), .fire_bad(fire_bad), .rd_fire(rd_fire),
    .num_d(slot_base + dec_vec), .irq_valid(irq_valid), .irq_num(irq_num),
    .irq_err(irq_err), .rd_ack(rd_ack));

  a_r4_pulse_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> $past(acc_valid && acc_write));
  a_r5_out_of_range_err: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !dec_in_range) |=> (irq_err && !irq_valid));
  a_r7_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> (rd_ack && !irq_valid && !irq_err));
  a_r2_slot_in_table: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (32'($past(acc_addr[ADDR_W-1:16])) < NUM_ENT));
endmodule

// File: tb/msi_doorbell_tb.sv
module msi_doorbell_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0;
  logic [19:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic rd_ack;
  logic [31:0] rd_data;
  logic cfg_load = 1'b0;
  logic [2:0] cfg_idx = '0;
  logic [15:0] cfg_base = '0;
  logic [5:0] cfg_count = '0;
  logic irq_valid, irq_err;
  logic [15:0] irq_num;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  msi_doorbell dut_i (.*);

  function automatic logic [15:0] expect_num(input logic [15:0] base, input logic [15:0] off,
                                             input logic [31:0] data);
    logic [31:0] v;
    v = 32'(off >> 2) | data;
    return 16'((32'(base) + v) & 32'hFFFF);
  endfunction

  task automatic check(input string tag, input logic v, input logic e, input logic [15:0] n,
                       input logic ev, input logic ee, input logic [15:0] en);
    checks++;
    if (v !== ev || e !== ee || (ev && n !== en)) begin
      errors++;
      $display("FAIL %s: valid=%0b err=%0b num=%h expected valid=%0b err=%0b num=%h",
               tag, v, e, n, ev, ee, en);
    end
  endtask

  task automatic load(input int idx, input logic [15:0] base, input logic [5:0] cnt);
    @(negedge clk);
    cfg_load = 1; cfg_idx = 3'(idx); cfg_base = base; cfg_count = cnt;
    @(negedge clk);
    cfg_load = 0;
  endtask

  task automatic wr(input int idx, input logic [15:0] off, input logic [31:0] data);
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_addr = {4'(idx), off}; acc_wdata = data;
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
  endtask

  task automatic t_reset;
    check("R1 reset outputs", irq_valid, irq_err | rd_ack, irq_num, 0, 0, 0);
    wr(0, 16'h0000, 0);
    check("R1 empty after reset", irq_valid, irq_err, irq_num, 0, 1, 0);
  endtask

  task automatic t_vectors;
    load(2, 16'h0100, 6'd4);
    wr(2, 16'h000C, 0);
    check("R3 address vector", irq_valid, irq_err, irq_num, 1, 0, expect_num(16'h0100, 16'h000C, 0));
    wr(2, 16'h0000, 32'd5);
    check("R3 data vector", irq_valid, irq_err, irq_num, 1, 0, expect_num(16'h0100, 0, 5));
    wr(2, 16'h0004, 32'd2);
    check("R3 OR of both", irq_valid, irq_err, irq_num, 1, 0, 16'h0103);
    load(7, 16'hFFFE, 6'd1);
    wr(7, 16'h000C, 0);
    check("R3 wrap", irq_valid, irq_err, irq_num, 1, 0, 16'h0001);
    load(3, 16'h0200, 6'd1);
    wr(3, 16'h0000, 0);
    check("R2 slot select", irq_valid, irq_err, irq_num, 1, 0, 16'h0200);
  endtask

  task automatic t_pulse;
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_addr = {4'd2, 16'h0004}; acc_wdata = 0;
    @(negedge clk);
    check("R4 first pulse", irq_valid, irq_err, irq_num, 1, 0, 16'h0101);
    acc_addr = {4'd3, 16'h0008};
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
    check("R4 second pulse", irq_valid, irq_err, irq_num, 1, 0, 16'h0202);
    @(negedge clk);
    check("R4 single cycle", irq_valid, irq_err, irq_num, 0, 0, 0);
  endtask

  task automatic t_errors;
    wr(8, 16'h0000, 0);
    check("R5 index beyond table", irq_valid, irq_err, irq_num, 0, 1, 0);
    wr(15, 16'h0004, 0);
    check("R5 top of address", irq_valid, irq_err, irq_num, 0, 1, 0);
    wr(5, 16'h0000, 0);
    check("R6 empty slot", irq_valid, irq_err, irq_num, 0, 1, 0);
  endtask

  task automatic t_read;
    @(negedge clk);
    acc_valid = 1; acc_write = 0; acc_addr = {4'd2, 16'h0000}; acc_wdata = 32'hFFFF;
    @(negedge clk);
    acc_valid = 0;
    checks++;
    if (rd_ack !== 1'b1 || rd_data !== 32'd0) begin
      errors++;
      $display("FAIL R7 read ack=%0b data=%h expected ack=1 data=0", rd_ack, rd_data);
    end
    check("R7 read quiet", irq_valid, irq_err, irq_num, 0, 0, 0);
    wr(2, 16'h0000, 0);
    check("R7 slot unchanged", irq_valid, irq_err, irq_num, 1, 0, 16'h0100);
  endtask

  task automatic t_collision;
    @(negedge clk);
    cfg_load = 1; cfg_idx = 3'd4; cfg_base = 16'h0400; cfg_count = 6'd2;
    acc_valid = 1; acc_write = 1; acc_addr = {4'd4, 16'h0000}; acc_wdata = 0;
    @(negedge clk);
    cfg_load = 0;
    check("R8 same-cycle uses old", irq_valid, irq_err, irq_num, 0, 1, 0);
    acc_addr = {4'd4, 16'h0004};
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
    check("R8 load visible next", irq_valid, irq_err, irq_num, 1, 0, 16'h0401);
    @(negedge clk);
    cfg_load = 1; cfg_idx = 3'd2; cfg_base = 16'h0900; cfg_count = 6'd1;
    acc_valid = 1; acc_write = 1; acc_addr = {4'd2, 16'h0000}; acc_wdata = 0;
    @(negedge clk);
    cfg_load = 0; acc_valid = 0; acc_write = 0;
    check("R8 old base kept", irq_valid, irq_err, irq_num, 1, 0, 16'h0100);
  endtask

  task automatic t_clear;
    load(2, 16'h0100, 6'd0);
    wr(2, 16'h0000, 0);
    check("R9 cleared slot", irq_valid, irq_err, irq_num, 0, 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_vectors();
    t_pulse();
    t_errors();
    t_read();
    t_collision();
    t_clear();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule